// File: doc/BRIEF.md
# Tone Burst/Pause Timing Controller

This block paces a tone transmitter. When burst mode is on and the transmitter is enabled, each new digit strobe starts a fixed-length tone-on interval. A silent interval of the same length follows it. Once both intervals have run out, the block raises a transmitter-ready status bit. If interrupts are enabled, it also raises an interrupt request. The interval length is a parameter in clock cycles, and call-progress mode doubles it. The default of 182,557 cycles gives about 51 ms from a 3.579545 MHz reference clock.

With burst mode off, the block does no timing. The tone-enable output follows the transmit-enable input directly, so software controls the tone length by switching the transmitter on and off.

The sequencer has three states:
- `ST_IDLE`: waiting for a digit.
- `ST_BURST`: tone on.
- `ST_PAUSE`: tone off, sequence still running.

It has three transitions:
- *accept* (`ST_IDLE`→`ST_BURST`): a digit strobe arrives while burst mode and transmit-enable are both high.
- *burst_done* (`ST_BURST`→`ST_PAUSE`): the interval timer expires.
- *pause_done* (`ST_PAUSE`→`ST_IDLE`): the interval timer expires again.

Top module: `tone_burst_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the block is in idle. `tx_ready` is 1 and `irq` is 0. With `tx_en` low, `tone_on` is 0.
- R2: While idle with `burst_en`=0, `tone_on` equals `tx_en` in the same cycle. A `digit_wr` pulse leaves `tx_ready` and `irq` unchanged.
- R3: While idle, a clock edge with `burst_en`, `tx_en` and `digit_wr` all high starts a sequence. From the next cycle, `tone_on`=1 and `tx_ready`=0.
- R4: With `cp_mode`=0 sampled at the accept edge, `tone_on` stays 1 for exactly BASE_CYCLES cycles. It then stays 0 for exactly BASE_CYCLES cycles of pause.
- R5: With `cp_mode`=1 sampled at the accept edge, both the burst and the pause last 2×BASE_CYCLES cycles. Changing `cp_mode` during the sequence has no effect on it.
- R6: In the cycle after the pause ends, `tx_ready` is 1. If `irq_en` was 1 at that edge, `irq` is also 1.
- R7: If `irq_en` is 0 when the pause ends, `irq` stays 0. `tx_ready` still becomes 1.
- R8: A `status_rd` pulse clears `irq` from the next cycle, unless a pause ends at that same edge. `tx_ready` is not changed.
- R9: A `digit_wr` pulse during a burst or a pause is ignored. The sequence keeps its timing, `tx_ready` stays 0, and no second sequence follows.
- R10: In burst mode with `tx_en`=0, `digit_wr` starts nothing: `tone_on` stays 0 and `tx_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| burst_en | input | 1 | Burst mode enable |
| cp_mode | input | 1 | 1 = call-progress timing (doubled), 0 = DTMF timing |
| irq_en | input | 1 | Interrupt enable |
| digit_wr | input | 1 | One-cycle strobe: a new digit was written |
| status_rd | input | 1 | One-cycle strobe: the status was read |
| tone_on | output | 1 | Enable to the tone generator |
| tx_ready | output | 1 | Transmitter ready for the next digit |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with BASE_CYCLES set to 10. A DTMF sequence then takes 20 cycles and a call-progress sequence takes 40. At that size, every cycle of every burst and pause can be compared against the expected waveform, including the exact edges where the tone falls and where ready and the interrupt rise. Short intervals also allow a digit to be injected in the middle of a burst and a mode change to be injected in the middle of a sequence, with the effect observed at the ports.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAUSE = 2'd2
    } tbc_state_e;
endpackage

// File: rtl/tbc_interval_timer.sv
module tbc_interval_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);
endmodule

// File: rtl/tbc_len_select.sv
module tbc_len_select #(
    parameter int BASE_CYCLES = 182557,
    parameter int CP_FACTOR   = 2,
    parameter int W           = 20
) (
    input  logic         long_sel,
    output logic [W-1:0] len_m1
);
    localparam logic [W-1:0] SHORT_M1 = W'(BASE_CYCLES - 1);
    localparam logic [W-1:0] LONG_M1  = W'(BASE_CYCLES * CP_FACTOR - 1);

    generate
        if (CP_FACTOR == 1) begin : g_flat
            assign len_m1 = SHORT_M1;
        end else begin : g_scaled
            assign len_m1 = long_sel ? LONG_M1 : SHORT_M1;
        end
    endgenerate
endmodule

// File: rtl/tbc_seq_fsm.sv
module tbc_seq_fsm
    import tbc_pkg::*;
#(
    parameter int W = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       burst_en,
    input  logic       cp_mode,
    input  logic       digit_wr,
    input  logic       expired,
    output tbc_state_e state,
    output logic       long_sel,
    output logic       tmr_load,
    output logic       accept,
    output logic       seq_done,
    output logic       tone_on
);
    tbc_state_e state_q, state_d;
    logic       cp_q;

    // State register, plus the mode latched at accept.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cp_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cp_q <= cp_mode;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (burst_en && tx_en && digit_wr) state_d = ST_BURST;
            ST_BURST: if (expired)                       state_d = ST_PAUSE;
            ST_PAUSE: if (expired)                       state_d = ST_IDLE;
            default:                                     state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        accept   = 1'b0;
        seq_done = 1'b0;
        tmr_load = 1'b0;
        long_sel = cp_q;
        tone_on  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept   = burst_en && tx_en && digit_wr;
                tmr_load = accept;
                long_sel = cp_mode;
                tone_on  = !burst_en && tx_en;
            end
            ST_BURST: begin
                tone_on  = 1'b1;
                tmr_load = expired;
            end
            ST_PAUSE: begin
                seq_done = expired;
            end
            default: begin
                tone_on = 1'b0;
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/tbc_flag_unit.sv
module tbc_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic seq_done,
    input  logic irq_en,
    input  logic status_rd,
    output logic tx_ready,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ready <= 1'b1;
        end else if (seq_done) begin
            tx_ready <= 1'b1;
        end else if (accept) begin
            tx_ready <= 1'b0;
        end
    end

    // A pause ending at the same edge as a read takes priority.
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (seq_done && irq_en) begin
            irq <= 1'b1;
        end else if (status_rd) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/tone_burst_ctrl.sv
module tone_burst_ctrl
    import tbc_pkg::*;
#(
    parameter int BASE_CYCLES = 182557,
    parameter int CP_FACTOR   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic burst_en,
    input  logic cp_mode,
    input  logic irq_en,
    input  logic digit_wr,
    input  logic status_rd,
    output logic tone_on,
    output logic tx_ready,
    output logic irq
);
    localparam int LONGEST = BASE_CYCLES * CP_FACTOR;
    localparam int W       = $clog2(LONGEST + 1);

    tbc_state_e   state_q;
    logic         long_sel;
    logic         tmr_load;
    logic         expired;
    logic         accept;
    logic         seq_done;
    logic [W-1:0] len_m1;

    tbc_len_select #(
        .BASE_CYCLES(BASE_CYCLES),
        .CP_FACTOR  (CP_FACTOR),
        .W          (W)
    ) u_len (
        .long_sel(long_sel),
        .len_m1  (len_m1)
    );

    tbc_interval_timer #(.W(W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(len_m1),
        .expired (expired)
    );

    tbc_seq_fsm #(.W(W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .tx_en   (tx_en),
        .burst_en(burst_en),
        .cp_mode (cp_mode),
        .digit_wr(digit_wr),
        .expired (expired),
        .state   (state_q),
        .long_sel(long_sel),
        .tmr_load(tmr_load),
        .accept  (accept),
        .seq_done(seq_done),
        .tone_on (tone_on)
    );

    tbc_flag_unit u_flags (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .seq_done (seq_done),
        .irq_en   (irq_en),
        .status_rd(status_rd),
        .tx_ready (tx_ready),
        .irq      (irq)
    );
endmodule

// File: rtl/tbc_checker.sv
module tbc_checker
    import tbc_pkg::*;
#(
    parameter int BASE_CYCLES = 182557,
    parameter int CP_FACTOR   = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       tx_en,
    input logic       burst_en,
    input logic       cp_mode,
    input logic       irq_en,
    input logic       digit_wr,
    input logic       status_rd,
    input logic       tone_on,
    input logic       tx_ready,
    input logic       irq,
    input tbc_state_e state_q
);
    localparam int CW = $clog2(BASE_CYCLES * CP_FACTOR + 2);

    logic [CW-1:0] burst_run, pause_run;
    logic          mode_q;
    logic [CW-1:0] want_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_run <= '0;
            pause_run <= '0;
            mode_q    <= 1'b0;
        end else begin
            burst_run <= (state_q == ST_BURST) ? burst_run + 1'b1 : '0;
            pause_run <= (state_q == ST_PAUSE) ? pause_run + 1'b1 : '0;
            if (state_q == ST_IDLE) mode_q <= cp_mode;
        end
    end

    assign want_len = mode_q ? CW'(BASE_CYCLES * CP_FACTOR) : CW'(BASE_CYCLES);

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && burst_en && tx_en && digit_wr) |=> (tone_on && !tx_ready)); // R3
    AST_BURST_SPAN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAUSE && $past(state_q) == ST_BURST) |-> (burst_run == want_len)); // R4
    AST_PAUSE_SPAN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && $past(state_q) == ST_PAUSE) |-> (pause_run == want_len)); // R5
    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAUSE) |-> !tone_on); // R4
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(state_q) == ST_PAUSE && $past(irq_en))); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (status_rd && state_q != ST_PAUSE) |=> !irq); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> !tx_ready); // R9
endmodule

bind tone_burst_ctrl tbc_checker #(
    .BASE_CYCLES(BASE_CYCLES),
    .CP_FACTOR  (CP_FACTOR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .burst_en (burst_en),
    .cp_mode  (cp_mode),
    .irq_en   (irq_en),
    .digit_wr (digit_wr),
    .status_rd(status_rd),
    .tone_on  (tone_on),
    .tx_ready (tx_ready),
    .irq      (irq),
    .state_q  (state_q)
);

// File: tb/sim_tone_burst_ctrl.sv
`timescale 1ns/1ps
module sim_tone_burst_ctrl;
    localparam int BASE = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0, burst_en = 1'b0, cp_mode = 1'b0, irq_en = 1'b0;
    logic digit_wr = 1'b0, status_rd = 1'b0;
    logic tone_on, tx_ready, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tone_burst_ctrl #(.BASE_CYCLES(BASE)) u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .burst_en(burst_en),
        .cp_mode(cp_mode), .irq_en(irq_en), .digit_wr(digit_wr),
        .status_rd(status_rd), .tone_on(tone_on), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Starts a sequence and compares every cycle of it; poke_at > 0 injects
    // another digit at that cycle, flip_at > 0 toggles cp_mode there.
    task automatic run_seq(input int len, input int poke_at, input int flip_at, input string req);
        int bad = 0;
        int first_e = 0;
        @(negedge clk);
        digit_wr = 1'b1;
        for (int e = 1; e <= 2 * len + 1; e++) begin
            @(negedge clk);
            if ((tone_on !== (e <= len)) || (tx_ready !== (e == 2 * len + 1))) begin
                if (bad == 0) first_e = e;
                bad++;
            end
            digit_wr = (e == poke_at);
            if (e == flip_at) cp_mode = ~cp_mode;
        end
        chk(bad == 0, req, first_e, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_ready === 1'b1, "R1 ready", tx_ready, 1);
        chk(irq === 1'b0, "R1 irq", irq, 0);
        chk(tone_on === 1'b0, "R1 tone", tone_on, 0);
    endtask

    task automatic t_bypass();
        burst_en = 1'b0;
        tx_en = 1'b1;
        #1;
        chk(tone_on === 1'b1, "R2 follow high", tone_on, 1);
        @(negedge clk);
        digit_wr = 1'b1;
        @(negedge clk);
        digit_wr = 1'b0;
        chk(tx_ready === 1'b1 && irq === 1'b0, "R2 digit no effect", {tx_ready, irq}, 2);
        tx_en = 1'b0;
        #1;
        chk(tone_on === 1'b0, "R2 follow low", tone_on, 0);
    endtask

    task automatic t_no_tx();
        burst_en = 1'b1;
        tx_en = 1'b0;
        @(negedge clk);
        digit_wr = 1'b1;
        @(negedge clk);
        digit_wr = 1'b0;
        @(negedge clk);
        chk(tone_on === 1'b0 && tx_ready === 1'b1, "R10 no start", {tone_on, tx_ready}, 1);
    endtask

    task automatic t_dtmf();
        burst_en = 1'b1; tx_en = 1'b1; cp_mode = 1'b0; irq_en = 1'b1;
        run_seq(BASE, 0, 0, "R3 R4 dtmf waveform");
        chk(irq === 1'b1, "R6 irq raised", irq, 1);
    endtask

    task automatic t_read();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        chk(irq === 1'b0, "R8 irq cleared", irq, 0);
        chk(tx_ready === 1'b1, "R8 ready kept", tx_ready, 1);
    endtask

    task automatic t_cp();
        cp_mode = 1'b1;
        run_seq(2 * BASE, 0, 5, "R5 cp waveform, mode flip ignored");
        chk(irq === 1'b1, "R6 irq after cp", irq, 1);
        cp_mode = 1'b0;
        t_read();
    endtask

    task automatic t_ignore();
        cp_mode = 1'b0;
        run_seq(BASE, 4, 0, "R9 digit in burst ignored");
        run_seq(BASE, BASE + 3, 0, "R9 digit in pause ignored");
        repeat (3) @(negedge clk);
        chk(tone_on === 1'b0 && tx_ready === 1'b1, "R9 no second sequence", {tone_on, tx_ready}, 1);
        t_read();
    endtask

    task automatic t_masked();
        irq_en = 1'b0;
        run_seq(BASE, 0, 0, "R7 waveform masked");
        chk(irq === 1'b0, "R7 irq stays low", irq, 0);
        chk(tx_ready === 1'b1, "R7 ready set", tx_ready, 1);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_no_tx();
        t_dtmf();
        t_read();
        t_cp();
        t_ignore();
        t_masked();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule